// File: doc/BRIEF.md
# Tile Input Conditioning Path

This block prepares the input bits of a logic tile before the tile's logic sees them. Each of the eight lanes has its own configuration. A selector picks where the lane's bit comes from: nothing, a square-wave stimulus, a fixed low, a fixed high, a custom-waveform stimulus, or the output of another tile. The chosen bit then passes through up to three optional stages, always in the same order. The first is a multi-flop synchronizer for asynchronous sources. The second is a one-cycle pipeline register. The third is an edge detector that turns level changes into one-cycle pulses.

The stimulus generators and the routing between tiles are outside this block. They arrive here only as plain input bits. A bit that comes from another tile is already synchronous to this clock. For that source the synchronizer is skipped even when it is enabled, and the pipeline stage is the one meant to be used.

Top module: `isc_tile_inputs`

## Requirements
- R1: The 3-bit source code of a lane selects its bit. 0 gives constant 0, 1 gives the square-wave input, 2 gives constant 0, 3 gives constant 1, 4 gives the custom-waveform input and 5 gives the tile-output input. Codes 6 and 7 give constant 0.
- R2: Each of the eight lanes uses only its own source code, enables, edge mode and input bits.
- R3: When a lane's pipeline enable is set, its output follows the selected signal exactly one clock cycle later.
- R4: When a lane's synchronizer enable is set and its source is not the tile output, its output follows the selected signal SYNC_STAGES cycles later (2 by default).
- R5: With the tile-output source (code 5), the synchronizer is bypassed whatever its enable says. With the pipeline also enabled, the latency is exactly one cycle.
- R6: The 2-bit edge mode works as follows. 0 passes the level through. 1 gives a one-cycle pulse on each rising edge. 2 gives a one-cycle pulse on each falling edge. 3 gives a one-cycle pulse on either edge.
- R7: The stages apply in the order synchronizer, then pipeline, then edge detector. Their latencies add, and a pulse marks an edge of the delayed signal.
- R8: Synchronous active-high reset clears the synchronizer, pipeline and edge reference flops. A pipelined output therefore reads 0 during reset, and a source held low through reset produces no pulse afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tile clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 8x3 | Per-lane source code |
| sync_en | input | 8 | Per-lane synchronizer enable |
| pipe_en | input | 8 | Per-lane pipeline enable |
| edge_mode | input | 8x2 | Per-lane edge mode |
| square_in | input | 8 | Square-wave stimulus bits |
| custom_in | input | 8 | Custom-waveform stimulus bits |
| tile_in | input | 8 | Bits from other tiles' outputs |
| lane_out | output | 8 | Conditioned bits |

## Verification
Some properties are checked on every cycle in every lane:
- a fixed-high source with no stages gives 1, and the constant-zero codes give 0;
- a pipelined square-wave source repeats its previous-cycle value;
- a pipelined tile-output source shows one-cycle latency regardless of the synchronizer enable;
- a single-edge mode never produces two high cycles in a row.

The exact two-cycle synchronizer latency, the independence of neighbouring lanes, the falling and both-edge pulse shapes, the additive three-cycle path and the reset behaviour are shown only by the bench's directed scenarios.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [2:0] {
        SRC_NONE   = 3'd0,
        SRC_SQUARE = 3'd1,
        SRC_LOW    = 3'd2,
        SRC_HIGH   = 3'd3,
        SRC_CUSTOM = 3'd4,
        SRC_TILE   = 3'd5
    } src_sel_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef struct packed {
        src_sel_e   sel;
        logic       sync_en;
        logic       pipe_en;
        edge_mode_e emode;
    } lane_cfg_t;

    typedef struct packed {
        logic square;
        logic custom;
        logic tile;
    } lane_src_t;

    function automatic logic pick_source(src_sel_e sel, lane_src_t s);
        case (sel)
            SRC_SQUARE: return s.square;
            SRC_HIGH:   return 1'b1;
            SRC_CUSTOM: return s.custom;
            SRC_TILE:   return s.tile;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic edge_pulse(edge_mode_e m, logic cur, logic prev);
        case (m)
            EDGE_RISE: return cur & ~prev;
            EDGE_FALL: return ~cur & prev;
            EDGE_BOTH: return cur ^ prev;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/isc_src_mux.sv
module isc_src_mux
    import isc_pkg::*;
(
    input  src_sel_e  sel,
    input  lane_src_t srcs,
    output logic      chosen,
    output logic      is_sync_src
);
    always_comb begin
        chosen      = pick_source(sel, srcs);
        is_sync_src = (sel == SRC_TILE);
    end
endmodule

// File: rtl/isc_sync.sv
module isc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[LAST];
endmodule

// File: rtl/isc_edge.sv
module isc_edge
    import isc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_mode_e mode,
    input  logic       level,
    output logic       y
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    always_comb y = edge_pulse(mode, level, prev_q);
endmodule

// File: rtl/isc_lane.sv
module isc_lane
    import isc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  lane_cfg_t cfg,
    input  lane_src_t srcs,
    output logic      y
);
    logic raw_bit;
    logic is_tile;
    logic synced_bit;
    logic after_sync;
    logic pipe_q;
    logic after_pipe;

    isc_src_mux u_mux (
        .sel         (cfg.sel),
        .srcs        (srcs),
        .chosen      (raw_bit),
        .is_sync_src (is_tile)
    );

    isc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bit),
        .q   (synced_bit)
    );

    always_comb after_sync = (cfg.sync_en && !is_tile) ? synced_bit : raw_bit;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= 1'b0;
        else     pipe_q <= after_sync;
    end

    always_comb after_pipe = cfg.pipe_en ? pipe_q : after_sync;

    isc_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .mode  (cfg.emode),
        .level (after_pipe),
        .y     (y)
    );
endmodule

// File: rtl/isc_tile_inputs.sv
module isc_tile_inputs
    import isc_pkg::*;
#(
    parameter int NUM_INPUTS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_INPUTS-1:0][2:0]  src_sel,
    input  logic [NUM_INPUTS-1:0]       sync_en,
    input  logic [NUM_INPUTS-1:0]       pipe_en,
    input  logic [NUM_INPUTS-1:0][1:0]  edge_mode,
    input  logic [NUM_INPUTS-1:0]       square_in,
    input  logic [NUM_INPUTS-1:0]       custom_in,
    input  logic [NUM_INPUTS-1:0]       tile_in,
    output logic [NUM_INPUTS-1:0]       lane_out
);
    generate
        for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_lane
            lane_cfg_t cfg;
            lane_src_t srcs;

            always_comb begin
                cfg.sel     = src_sel_e'(src_sel[i]);
                cfg.sync_en = sync_en[i];
                cfg.pipe_en = pipe_en[i];
                cfg.emode   = edge_mode_e'(edge_mode[i]);
                srcs.square = square_in[i];
                srcs.custom = custom_in[i];
                srcs.tile   = tile_in[i];
            end

            isc_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
                .clk  (clk),
                .rst  (rst),
                .cfg  (cfg),
                .srcs (srcs),
                .y    (lane_out[i])
            );
        end
    endgenerate
endmodule

// File: rtl/isc_tile_inputs_chk.sv
module isc_tile_inputs_chk #(
    parameter int NUM_INPUTS = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_INPUTS-1:0][2:0] src_sel,
    input logic [NUM_INPUTS-1:0]      sync_en,
    input logic [NUM_INPUTS-1:0]      pipe_en,
    input logic [NUM_INPUTS-1:0][1:0] edge_mode,
    input logic [NUM_INPUTS-1:0]      square_in,
    input logic [NUM_INPUTS-1:0]      tile_in,
    input logic [NUM_INPUTS-1:0]      lane_out
);
    generate
        for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_chk
            AST_CONST_HIGH: assert property (@(posedge clk) disable iff (rst)
                (src_sel[i] == 3'd3 && !sync_en[i] && !pipe_en[i] && edge_mode[i] == 2'd0)
                |-> lane_out[i]); // R1

            AST_CONST_ZERO: assert property (@(posedge clk) disable iff (rst)
                ((src_sel[i] == 3'd0 || src_sel[i] == 3'd2 || src_sel[i] >= 3'd6)
                 && !sync_en[i] && !pipe_en[i] && edge_mode[i] == 2'd0)
                |-> !lane_out[i]); // R1

            AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (rst)
                (src_sel[i] == 3'd1 && !sync_en[i] && pipe_en[i] && edge_mode[i] == 2'd0
                 && $past(!rst) && $past(src_sel[i] == 3'd1 && !sync_en[i] && pipe_en[i]))
                |-> lane_out[i] == $past(square_in[i])); // R3

            AST_TILE_BYPASS: assert property (@(posedge clk) disable iff (rst)
                (src_sel[i] == 3'd5 && pipe_en[i] && edge_mode[i] == 2'd0
                 && $past(!rst) && $past(src_sel[i] == 3'd5 && pipe_en[i]))
                |-> lane_out[i] == $past(tile_in[i])); // R5

            AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
                ((edge_mode[i] == 2'd1 || edge_mode[i] == 2'd2) && $stable(edge_mode[i])
                 && $past(!rst) && $past(lane_out[i]))
                |-> !lane_out[i]); // R6
        end
    endgenerate
endmodule

bind isc_tile_inputs isc_tile_inputs_chk #(.NUM_INPUTS(NUM_INPUTS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .sync_en   (sync_en),
    .pipe_en   (pipe_en),
    .edge_mode (edge_mode),
    .square_in (square_in),
    .tile_in   (tile_in),
    .lane_out  (lane_out)
);

// File: tb/isc_tile_inputs_tb.sv
module isc_tile_inputs_tb_top;
    localparam int N = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N-1:0][2:0]  src_sel   = '0;
    logic [N-1:0]       sync_en   = '0;
    logic [N-1:0]       pipe_en   = '0;
    logic [N-1:0][1:0]  edge_mode = '0;
    logic [N-1:0]       square_in = '0;
    logic [N-1:0]       custom_in = '0;
    logic [N-1:0]       tile_in   = '0;
    logic [N-1:0]       lane_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    isc_tile_inputs dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_sel   (src_sel),
        .sync_en   (sync_en),
        .pipe_en   (pipe_en),
        .edge_mode (edge_mode),
        .square_in (square_in),
        .custom_in (custom_in),
        .tile_in   (tile_in),
        .lane_out  (lane_out)
    );

    task automatic step(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, int lane, logic exp);
        #1;
        check(req, {{(N-1){1'b0}}, lane_out[lane]}, {{(N-1){1'b0}}, exp});
    endtask

    task automatic cfg_lane(int lane, logic [2:0] sel, logic s, logic p, logic [1:0] m);
        src_sel[lane]   = sel;
        sync_en[lane]   = s;
        pipe_en[lane]   = p;
        edge_mode[lane] = m;
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) cfg_lane(i, 3'd3, 1'b0, 1'b1, 2'd0);
        step(2);
        check("R8 pipelined out during reset", lane_out, '0);
        for (int i = 0; i < N; i++) cfg_lane(i, 3'd2, 1'b0, 1'b0, 2'd1);
        step(1);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step(1);
            check("R8 no pulse after reset", lane_out, '0);
        end
    endtask

    task automatic t_sources();
        for (int i = 0; i < N; i++) cfg_lane(i, 3'd0, 1'b0, 1'b0, 2'd0);
        square_in = '1; custom_in = '0; tile_in = '1;
        begin
            logic exp_a [8] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
            for (int c = 0; c < 8; c++) begin
                src_sel[0] = 3'(c);
                check_bit("R1 source code set A", 0, exp_a[c]);
            end
        end
        square_in = '0; custom_in = '1; tile_in = '0;
        src_sel[0] = 3'd1; check_bit("R1 square low", 0, 1'b0);
        src_sel[0] = 3'd4; check_bit("R1 custom high", 0, 1'b1);
        src_sel[0] = 3'd5; check_bit("R1 tile low", 0, 1'b0);
        src_sel[0] = 3'd7; check_bit("R1 code 7 zero", 0, 1'b0);
    endtask

    task automatic t_lanes();
        logic [2:0] sels [8] = '{3'd3, 3'd2, 3'd1, 3'd4, 3'd5, 3'd0, 3'd3, 3'd1};
        for (int i = 0; i < N; i++) cfg_lane(i, sels[i], 1'b0, 1'b0, 2'd0);
        square_in = 8'b0000_0100;
        custom_in = 8'b0000_1000;
        tile_in   = 8'b1110_1111;
        #1;
        check("R2 independent lanes", lane_out, 8'h4D);
    endtask

    task automatic t_pipe();
        logic bits [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
        cfg_lane(0, 3'd1, 1'b0, 1'b1, 2'd0);
        square_in[0] = 1'b0;
        step(2);
        for (int k = 0; k < 5; k++) begin
            square_in[0] = bits[k];
            check_bit("R3 before edge holds old", 0, (k == 0) ? 1'b0 : bits[k-1]);
            step(1);
            check_bit("R3 one cycle later", 0, bits[k]);
        end
    endtask

    task automatic t_sync();
        cfg_lane(1, 3'd4, 1'b1, 1'b0, 2'd0);
        custom_in[1] = 1'b0;
        step(3);
        custom_in[1] = 1'b1;
        step(1); check_bit("R4 rise not yet after 1", 1, 1'b0);
        step(1); check_bit("R4 rise after 2", 1, 1'b1);
        custom_in[1] = 1'b0;
        step(1); check_bit("R4 fall not yet after 1", 1, 1'b1);
        step(1); check_bit("R4 fall after 2", 1, 1'b0);
    endtask

    task automatic t_tile();
        cfg_lane(2, 3'd5, 1'b1, 1'b1, 2'd0);
        tile_in[2] = 1'b0;
        step(3);
        tile_in[2] = 1'b1;
        step(1); check_bit("R5 tile bypasses sync rise", 2, 1'b1);
        tile_in[2] = 1'b0;
        step(1); check_bit("R5 tile bypasses sync fall", 2, 1'b0);
    endtask

    task automatic t_edges();
        cfg_lane(3, 3'd4, 1'b0, 1'b0, 2'd1);
        custom_in[3] = 1'b0;
        step(2);
        custom_in[3] = 1'b1; check_bit("R6 rise pulse", 3, 1'b1);
        step(1);             check_bit("R6 rise pulse one cycle", 3, 1'b0);
        custom_in[3] = 1'b0; check_bit("R6 rise ignores fall", 3, 1'b0);
        step(1);
        edge_mode[3] = 2'd2;
        custom_in[3] = 1'b1; check_bit("R6 fall ignores rise", 3, 1'b0);
        step(1);
        custom_in[3] = 1'b0; check_bit("R6 fall pulse", 3, 1'b1);
        step(1);             check_bit("R6 fall pulse one cycle", 3, 1'b0);
        edge_mode[3] = 2'd3;
        custom_in[3] = 1'b1; check_bit("R6 both on rise", 3, 1'b1);
        step(1);             check_bit("R6 both clears", 3, 1'b0);
        custom_in[3] = 1'b0; check_bit("R6 both on fall", 3, 1'b1);
        step(1);             check_bit("R6 both clears again", 3, 1'b0);
    endtask

    task automatic t_order();
        cfg_lane(4, 3'd1, 1'b1, 1'b1, 2'd1);
        square_in[4] = 1'b0;
        step(5);
        square_in[4] = 1'b1; check_bit("R7 no pulse at once", 4, 1'b0);
        step(1); check_bit("R7 no pulse after 1", 4, 1'b0);
        step(1); check_bit("R7 no pulse after 2", 4, 1'b0);
        step(1); check_bit("R7 pulse after 3", 4, 1'b1);
        step(1); check_bit("R7 pulse ends", 4, 1'b0);
    endtask

    initial begin
        #1;
        t_reset();
        t_sources();
        t_lanes();
        t_pipe();
        t_sync();
        t_tile();
        t_edges();
        t_order();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule